// File: doc/BRIEF.md
# Slotted Round-Robin Bus Arbiter

This arbiter decides, in every clock cycle and without memory of earlier decisions beyond two pointers, which one of `N_INIT` initiators may drive a shared bus. A small programmable slot table assigns each position of a repeating time frame to one owning initiator, or leaves it unassigned. A slot pointer steps through the table once per cycle. When the owner of the current slot is requesting, that owner is granted. This gives every owner a fixed share of bandwidth and a bounded wait.

When the current slot is unassigned, or its owner is not requesting, the cycle is not wasted. It goes to the first requesting initiator found by a circular search that starts at a round-robin pointer. That pointer then moves to one past the winner. Bursty, unscheduled traffic therefore shares all the slack left over by the guaranteed schedule.

The grant is combinational from the request vector and the two registered pointers. Software or a configuration sequencer fills the slot table through a one-entry-per-cycle write port.

Top module: `tdma_rr_arb`

## Requirements
- R1: `gnt` has at most one bit set, and a set bit is always one whose `req` bit is also set.
- R2: If the current slot entry is assigned and its owner's `req` bit is set, that owner is granted with `gnt_tdma`=1, and the round-robin pointer keeps its value for the next cycle.
- R3: If the current entry is assigned but its owner is not requesting, the grant goes to the first set `req` bit at index p, p+1, … wrapping modulo `N_INIT`, where p is the round-robin pointer. `gnt_tdma` is 0, and p becomes (winner+1) mod `N_INIT` at the next clock.
- R4: A table entry written with `tbl_assign`=0 is unassigned, and every cycle on it is arbitrated purely as in R3 whatever `tbl_owner` was written.
- R5: `slot_idx` increases by one on every clock after reset, wrapping from `N_SLOTS`-1 to 0, independent of requests and grants.
- R6: Reset sets `slot_idx` to 0, the round-robin pointer to 0 and every table entry to unassigned.
- R7: With `req` all zero, `gnt` is all zero, `gnt_tdma` is 0 and the round-robin pointer is unchanged.
- R8: A table write with `tbl_we`=1 changes only entry `tbl_addr`, and the new contents first govern the cycle after the write clock edge.
- R9: An initiator that keeps requesting is granted before it has been passed over in `N_INIT` cycles whose grant came from the round-robin phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | N_INIT | One request bit per initiator |
| tbl_we | input | 1 | Slot table write enable |
| tbl_addr | input | SW | Slot table entry to write |
| tbl_assign | input | 1 | 1 = entry has an owner, 0 = unassigned |
| tbl_owner | input | IDW | Owning initiator index for the written entry |
| gnt | output | N_INIT | One-hot or zero grant vector |
| gnt_tdma | output | 1 | 1 when the grant came from the slot owner phase |
| slot_idx | output | SW | Current slot table position |

## Verification
The assertions assume that every assigned table entry names an initiator below `N_INIT`, and that a starvation bound only applies while an initiator's request stays continuously high. The stimulus writes only legal owner indices. It also holds an all-request phase long enough for the round-robin bound to matter, while other phases toggle requests freely. Table writes, including writes to the slot currently in use, are applied with the reset released. They are sequenced so the reference model's one-cycle write latency lines up with the design.

// File: rtl/tdma_rr_pkg.sv
package tdma_rr_pkg;

  // circular increment of an index over a range of lim values
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction

  // width of an index over n items, at least one bit
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/arb_slot_table.sv
module arb_slot_table #(
  parameter int N_SLOTS = 8,
  parameter int IDW     = 2,
  parameter int SW      = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [SW-1:0]  wr_addr,
  input  logic           wr_assign,
  input  logic [IDW-1:0] wr_owner,
  input  logic [SW-1:0]  rd_addr,
  output logic           rd_assign,
  output logic [IDW-1:0] rd_owner
);

  logic [N_SLOTS-1:0] assign_q;
  logic [IDW-1:0]     owner_q [N_SLOTS];

  for (genvar e = 0; e < N_SLOTS; e++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_addr == SW'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        assign_q[e] <= 1'b0;
        owner_q[e]  <= '0;
      end else if (hit) begin
        assign_q[e] <= wr_assign;
        owner_q[e]  <= wr_owner;
      end
    end
  end

  always_comb begin
    rd_assign = 1'b0;
    rd_owner  = '0;
    for (int e = 0; e < N_SLOTS; e++) begin
      if (rd_addr == SW'(e)) begin
        rd_assign = assign_q[e];
        rd_owner  = owner_q[e];
      end
    end
  end

endmodule

// File: rtl/arb_slot_seq.sv
module arb_slot_seq #(
  parameter int N_SLOTS = 8,
  parameter int SW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [SW-1:0] slot_q
);
  import tdma_rr_pkg::*;

  logic [SW-1:0] slot_nx;
  assign slot_nx = SW'(wrap_inc(int'(slot_q), N_SLOTS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_nx;
  end

endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N_INIT = 4,
  parameter int IDW    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_INIT-1:0] cand,
  output logic              found,
  output logic [IDW-1:0]    winner,
  output logic [IDW-1:0]    ptr_q
);
  import tdma_rr_pkg::*;

  // first set bit of c at or after p, searching circularly
  function automatic logic [IDW:0] first_from(input logic [N_INIT-1:0] c, input int unsigned p);
    logic [IDW:0] res;
    int unsigned  pos;
    res = '0;
    for (int k = N_INIT - 1; k >= 0; k--) begin
      pos = (p + k) % N_INIT;
      if (c[pos]) res = {1'b1, IDW'(pos)};
    end
    return res;
  endfunction

  logic [IDW:0]   pick;
  logic [IDW-1:0] ptr_nx;

  assign pick   = first_from(cand, int'(ptr_q));
  assign found  = pick[IDW];
  assign winner = pick[IDW-1:0];
  assign ptr_nx = IDW'(wrap_inc(int'(winner), N_INIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_q <= '0;
    else if (found) ptr_q <= ptr_nx;
  end

endmodule

// File: rtl/tdma_rr_arb.sv
module tdma_rr_arb #(
  parameter int N_INIT  = 4,
  parameter int N_SLOTS = 8,
  parameter int IDW     = tdma_rr_pkg::idx_width(N_INIT),
  parameter int SW      = tdma_rr_pkg::idx_width(N_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_INIT-1:0] req,
  input  logic              tbl_we,
  input  logic [SW-1:0]     tbl_addr,
  input  logic              tbl_assign,
  input  logic [IDW-1:0]    tbl_owner,
  output logic [N_INIT-1:0] gnt,
  output logic              gnt_tdma,
  output logic [SW-1:0]     slot_idx
);

  logic              cur_assign;
  logic [IDW-1:0]    cur_owner;
  logic              owner_hit;
  logic [N_INIT-1:0] rr_cand;
  logic              rr_found;
  logic [IDW-1:0]    rr_winner;
  logic [IDW-1:0]    rr_ptr;
  logic              rr_event;

  arb_slot_seq #(.N_SLOTS(N_SLOTS), .SW(SW)) u_seq (
    .clk(clk), .rst_n(rst_n), .slot_q(slot_idx)
  );

  arb_slot_table #(.N_SLOTS(N_SLOTS), .IDW(IDW), .SW(SW)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_we), .wr_addr(tbl_addr), .wr_assign(tbl_assign), .wr_owner(tbl_owner),
    .rd_addr(slot_idx), .rd_assign(cur_assign), .rd_owner(cur_owner)
  );

  // guaranteed phase: owner of the current slot asks for the bus
  always_comb begin
    owner_hit = 1'b0;
    for (int i = 0; i < N_INIT; i++)
      if (cur_assign && cur_owner == IDW'(i) && req[i]) owner_hit = 1'b1;
  end

  // slack phase sees requests only when the slot is left idle
  assign rr_cand = owner_hit ? '0 : req;

  arb_rr_pick #(.N_INIT(N_INIT), .IDW(IDW)) u_rr (
    .clk(clk), .rst_n(rst_n), .cand(rr_cand),
    .found(rr_found), .winner(rr_winner), .ptr_q(rr_ptr)
  );

  assign rr_event = rr_found;
  assign gnt_tdma = owner_hit;

  for (genvar i = 0; i < N_INIT; i++) begin : g_gnt
    assign gnt[i] = owner_hit ? (cur_owner == IDW'(i)) : (rr_found && rr_winner == IDW'(i));
  end

endmodule

// File: rtl/tdma_rr_arb_chk.sv
module tdma_rr_arb_chk #(
  parameter int N_INIT  = 4,
  parameter int N_SLOTS = 8,
  parameter int IDW     = 2,
  parameter int SW      = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_INIT-1:0] req,
  input logic [N_INIT-1:0] gnt,
  input logic              gnt_tdma,
  input logic [SW-1:0]     slot_idx,
  input logic              owner_hit,
  input logic [IDW-1:0]    cur_owner,
  input logic [IDW-1:0]    rr_ptr,
  input logic              rr_event
);
  import tdma_rr_pkg::*;

  localparam int CW = idx_width(N_INIT + 1) + 1;

  function automatic logic [IDW-1:0] after_grant(input logic [N_INIT-1:0] g);
    logic [IDW-1:0] r;
    r = '0;
    for (int i = 0; i < N_INIT; i++)
      if (g[i]) r = IDW'(wrap_inc(i, N_INIT));
    return r;
  endfunction

  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  p_gnt_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && ((gnt & ~req) == '0));

  p_owner_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    owner_hit |-> (gnt[cur_owner] && gnt_tdma));

  p_owner_keeps_ptr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    owner_hit |=> $stable(rr_ptr));

  p_rr_ptr_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_event && !gnt_tdma) |=> (rr_ptr == after_grant($past(gnt))));

  p_slot_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (slot_idx == SW'(wrap_inc(int'($past(slot_idx)), N_SLOTS))));

  p_idle_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |-> (gnt == '0 && !gnt_tdma));

  p_idle_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |=> $stable(rr_ptr));

  for (genvar i = 0; i < N_INIT; i++) begin : g_wait
    logic [CW-1:0] pass_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      pass_cnt <= '0;
      else if (!req[i] || gnt[i])      pass_cnt <= '0;
      else if (rr_event && !gnt_tdma && pass_cnt != '1) pass_cnt <= pass_cnt + 1'b1;
    end
    p_no_starve_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pass_cnt <= CW'(N_INIT - 1));
  end

endmodule

bind tdma_rr_arb tdma_rr_arb_chk #(
  .N_INIT(N_INIT), .N_SLOTS(N_SLOTS), .IDW(IDW), .SW(SW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt), .gnt_tdma(gnt_tdma),
  .slot_idx(slot_idx), .owner_hit(owner_hit), .cur_owner(cur_owner),
  .rr_ptr(rr_ptr), .rr_event(rr_event)
);

// File: tb/tb_tdma_rr_arb.sv
module tb_tdma_rr_arb;
  localparam int N = 4;
  localparam int S = 8;
  localparam int IDW = 2;
  localparam int SW = 3;
  localparam time CLK_PERIOD = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic [N-1:0] req = '0;
  logic tbl_we = 0;
  logic [SW-1:0] tbl_addr = '0;
  logic tbl_assign = 0;
  logic [IDW-1:0] tbl_owner = '0;
  logic [N-1:0] gnt;
  logic gnt_tdma;
  logic [SW-1:0] slot_idx;

  int checks = 0;
  int fails = 0;

  // reference model state
  int m_slot = 0;
  int m_ptr = 0;
  bit m_v [S];
  int m_o [S];
  int m_wait [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  tdma_rr_arb #(.N_INIT(N), .N_SLOTS(S)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_assign(tbl_assign), .tbl_owner(tbl_owner), .gnt(gnt), .gnt_tdma(gnt_tdma),
    .slot_idx(slot_idx)
  );

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] r, input bit we, input int wa, input bit wv, input int wo);
    int widx;
    bit wt;
    logic [N-1:0] eg;
    string tag;
    req = r; tbl_we = we; tbl_addr = SW'(wa); tbl_assign = wv; tbl_owner = IDW'(wo);
    #1;
    widx = -1; wt = 0;
    if (m_v[m_slot] && r[m_o[m_slot]]) begin widx = m_o[m_slot]; wt = 1; end
    else begin
      for (int k = 0; k < N; k++) begin
        if (widx < 0 && r[(m_ptr + k) % N]) widx = (m_ptr + k) % N;
      end
    end
    eg = '0;
    if (widx >= 0) eg[widx] = 1'b1;
    tag = (r == '0) ? "R7" : wt ? "R2" : m_v[m_slot] ? "R3" : "R4";
    check(gnt == eg, tag, "gnt", int'(gnt), int'(eg));
    check(gnt_tdma == wt, tag, "gnt_tdma", int'(gnt_tdma), int'(wt));
    check(slot_idx == SW'(m_slot), "R5", "slot_idx", int'(slot_idx), m_slot);
    check($onehot0(gnt) && ((gnt & ~r) == '0), "R1", "gnt legal", int'(gnt), int'(eg));
    for (int i = 0; i < N; i++) begin
      if (!r[i] || widx == i) m_wait[i] = 0;
      else if (widx >= 0 && !wt) m_wait[i]++;
      if (m_wait[i] > N - 1) check(0, "R9", "passed over", m_wait[i], N - 1);
    end
    @(posedge clk);
    if (widx >= 0 && !wt) m_ptr = (widx + 1) % N;
    m_slot = (m_slot + 1) % S;
    if (we) begin m_v[wa] = wv; m_o[wa] = wo; end
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic run(input logic [N-1:0] r, input int n);
    for (int c = 0; c < n; c++) step(r, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    check(0, "R1", "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    for (int s = 0; s < S; s++) begin m_v[s] = 0; m_o[s] = 0; end
    for (int i = 0; i < N; i++) m_wait[i] = 0;
    repeat (3) @(negedge clk);
    // R6: reset state visible before the first active edge
    check(slot_idx == '0, "R6", "slot after reset", int'(slot_idx), 0);
    check(gnt == '0, "R6", "gnt in reset, no req", int'(gnt), 0);
    rst_n = 1;
    // R6/R4: empty table, pointer from 0, rotation over all requesters
    run('1, 10);
    run(4'b0000, 3);                       // R7
    run(4'b1010, 6);
    // R8: program the table, owners 0,1,-,2,3,0,-,-
    step('0, 1, 0, 1, 0);
    step('0, 1, 1, 1, 1);
    step('0, 1, 2, 0, 3);                  // R4: unassigned, owner ignored
    step('0, 1, 3, 1, 2);
    step('0, 1, 4, 1, 3);
    step('0, 1, 5, 1, 0);
    step('0, 1, 6, 0, 0);
    step('0, 1, 7, 0, 0);
    run('1, 24);                           // R2/R9 under full load
    run(4'b0001, 10);
    run(4'b0110, 12);
    // R8: rewrite the slot in use now; applies from its next visit
    step(4'b1111, 1, m_slot, 1, 3);
    run(4'b1111, 9);
    lf = 32'h1ace_b00c;
    for (int c = 0; c < 400; c++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      if (c % 37 == 0) step(lf[3:0], 1, int'(lf[10:8]), lf[11], int'(lf[13:12]));
      else step(lf[3:0], 0, 0, 0, 0);
    end
    run('0, 4);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule